// File: doc/BRIEF.md
# Exception Priority Arbiter

This block sits beside a processor core and decides which exception the core takes, and on which cycle. It watches two active-low reset pins (power-on and manual), a watchdog overflow pulse, the trace bit together with the two-bit interrupt control mode, a sleep-driven direct-transition request, a pending-interrupt flag, a trap-instruction strobe, and completion strobes for instructions and for exception handling. When it accepts an exception, it raises `accept` for one cycle and puts the exception code on `exc_kind`. `reset_kind` says whether the last reset was a power-on reset or a manual reset.

The core of the block is a four-state machine. The states are:

- `ST_HOLD`: a reset pin is held low.
- `ST_RST_HANDLE`: reset handling is in progress.
- `ST_RUN`: the core is executing the program.
- `ST_EXC_HANDLE`: handling of some other exception is in progress.

The transitions are named as follows:

- *release*: `ST_HOLD` to `ST_RST_HANDLE`, when both synchronized pins are high again. A reset is accepted.
- *pin-drop*: any other state to `ST_HOLD`, when a synchronized pin is low.
- *watchdog*: `ST_RUN`, `ST_RST_HANDLE` or `ST_EXC_HANDLE` to `ST_RST_HANDLE`, on a watchdog overflow.
- *take*: to `ST_EXC_HANDLE`, when a non-reset exception is accepted.
- *resume*: `ST_RST_HANDLE` or `ST_EXC_HANDLE` to `ST_RUN`, on `handler_done` with nothing accepted.

Each request is qualified first and then passed to a fixed-priority picker. From highest to lowest, the order is reset, trace, direct transition, interrupt, trap.

An instruction completion (`insn_done` while running) is a sampling point. So is the end of exception handling (`handler_done` while handling). Interrupts are sampled only at these points, and so is trace. Trace also needs the trace bit set and the control mode equal to 2. It is skipped when the completing instruction is a return-from-exception. Interrupts are masked when the completing instruction modifies the condition register. They are also masked at the first sampling point after a reset is accepted.

Top module: `exc_arbiter`

## Requirements
- R1: The reset exception is accepted when both reset pins are high again after either was low, including after `rst_n` deasserts. `accept`=1 and `exc_kind`=1 appear on the third rising edge after both pins are high (two-flop synchronizer, then a registered output).
- R2: While the power-on pin is low (seen after synchronization), `in_reset`=1 and `reset_kind`=0 (power-on). While the manual pin alone is low, `in_reset`=1 and `reset_kind`=1 (manual). No exception is accepted while `in_reset`=1, and `reset_kind` keeps its value after release.
- R3: A watchdog overflow in any state other than hold is accepted as a reset with `reset_kind`=0. It outranks every other request. A watchdog overflow during hold is ignored.
- R4: When several requests qualify in the same cycle, only the highest one is accepted. The order is reset (1) > trace (2) > direct transition (3) > interrupt (4) > trap (5).
- R5: Trace (code 2) is accepted only at a sampling point, with `trace_bit`=1 and `irq_ctl_mode`=2. It is not accepted at the completion of an instruction flagged `insn_ret`.
- R6: A direct transition (code 3) is accepted when `sleep_exec` and `direct_req` are both 1 while running. Either one alone has no effect.
- R7: An interrupt (code 4) is accepted only at a sampling point with `irq_pending`=1. It is not accepted at the completion of an instruction flagged `insn_flagmod`.
- R8: After a reset is accepted, the next sampling point does not accept an interrupt. Interrupt sampling is normal again from the following sampling point.
- R9: A trap (code 5) is accepted on any cycle in the running state. It is not accepted while an exception is being handled.
- R10: `accept` is high for one cycle per accepted exception, with `exc_kind` in 1..5. When `accept`=0, `exc_kind`=0.
- R11: While a non-reset exception is being handled, `insn_done`, `trap_strobe` and the sleep-driven request have no effect. `handler_done` acts as the sampling point for trace and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low. Clears the synchronizers, so the block starts in hold. |
| pin_por_n | input | 1 | Power-on reset pin, active low, asynchronous |
| pin_warm_n | input | 1 | Manual reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| trace_bit | input | 1 | Trace enable bit from the status register |
| irq_ctl_mode | input | 2 | Interrupt control mode. Trace is allowed only in mode 2. |
| sleep_exec | input | 1 | A sleep instruction is executing |
| direct_req | input | 1 | A direct transition is requested for the sleep |
| irq_pending | input | 1 | An interrupt request is pending |
| trap_strobe | input | 1 | A trap instruction has been executed |
| insn_done | input | 1 | An instruction completes this cycle |
| insn_ret | input | 1 | The completing instruction is a return-from-exception |
| insn_flagmod | input | 1 | The completing instruction modifies the condition register |
| handler_done | input | 1 | Exception handling completes this cycle |
| accept | output | 1 | One-cycle pulse when an exception is accepted |
| exc_kind | output | 3 | 0 none, 1 reset, 2 trace, 3 direct, 4 interrupt, 5 trap |
| reset_kind | output | 1 | 0 power-on (or watchdog), 1 manual |
| in_reset | output | 1 | A reset pin is held low |

## Verification
The hardest situation to reach is the one-shot interrupt mask after reset. It only shows up at the first sampling point that follows a reset acceptance, and a later sampling point no longer shows it. The stimulus reaches it directly: after the power-on release, and again after a watchdog reset, it raises `handler_done` together with `irq_pending` and expects no acceptance. The pin-driven paths are reached by holding a pin low for three edges and then counting edges exactly from release to the accept pulse.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

    typedef enum logic [2:0] {
        EXC_NONE   = 3'd0,
        EXC_RESET  = 3'd1,
        EXC_TRACE  = 3'd2,
        EXC_DIRECT = 3'd3,
        EXC_IRQ    = 3'd4,
        EXC_TRAP   = 3'd5
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_RST_HANDLE,
        ST_RUN,
        ST_EXC_HANDLE
    } arb_state_e;

    // Request slots, highest priority at index 0; code = index + 1
    localparam int NUM_SRC   = 5;
    localparam int SLOT_RST  = 0;
    localparam int SLOT_TRC  = 1;
    localparam int SLOT_DIR  = 2;
    localparam int SLOT_IRQ  = 3;
    localparam int SLOT_TRAP = 4;

endpackage

// File: rtl/exc_pin_sync.sv
module exc_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/exc_req_qual.sv
module exc_req_qual #(
    parameter int MODE_W     = 2,
    parameter int TRACE_MODE = 2
) (
    input  logic              running,
    input  logic              handling,
    input  logic              insn_done,
    input  logic              handler_done,
    input  logic              insn_ret,
    input  logic              insn_flagmod,
    input  logic              trace_bit,
    input  logic [MODE_W-1:0] irq_ctl_mode,
    input  logic              sleep_exec,
    input  logic              direct_req,
    input  logic              irq_pending,
    input  logic              trap_strobe,
    input  logic              irq_mask,
    output logic              sample_pt,
    output logic              req_trace,
    output logic              req_direct,
    output logic              req_irq,
    output logic              req_trap
);

    localparam logic [MODE_W-1:0] TRC_MODE = MODE_W'(TRACE_MODE);

    logic insn_end;

    always_comb begin
        insn_end   = running & insn_done;
        sample_pt  = insn_end | (handling & handler_done);
        req_trace  = sample_pt & trace_bit & (irq_ctl_mode == TRC_MODE)
                   & ~(insn_end & insn_ret);
        req_direct = running & sleep_exec & direct_req;
        req_irq    = sample_pt & irq_pending & ~irq_mask
                   & ~(insn_end & insn_flagmod);
        req_trap   = running & trap_strobe;
    end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N      = 5,
    parameter int CODE_W = 3
) (
    input  logic [N-1:0]      req,
    output logic [N-1:0]      grant,
    output logic              any,
    output logic [CODE_W-1:0] code
);

    logic [N:0] taken;
    assign taken[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            assign grant[g]   = req[g] & ~taken[g];
            assign taken[g+1] = taken[g] | req[g];
        end
    endgenerate

    assign any = taken[N];

    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) code = CODE_W'(i + 1);
        end
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MODE_W      = 2,
    parameter int TRACE_MODE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_por_n,
    input  logic              pin_warm_n,
    input  logic              wdt_ovf,
    input  logic              trace_bit,
    input  logic [MODE_W-1:0] irq_ctl_mode,
    input  logic              sleep_exec,
    input  logic              direct_req,
    input  logic              irq_pending,
    input  logic              trap_strobe,
    input  logic              insn_done,
    input  logic              insn_ret,
    input  logic              insn_flagmod,
    input  logic              handler_done,
    output logic              accept,
    output logic [2:0]        exc_kind,
    output logic              reset_kind,
    output logic              in_reset
);

    localparam int CODE_W = 3;

    arb_state_e st_q, st_d;
    logic [1:0] pins_s;
    logic       por_s, warm_s, pins_ok;
    logic       mask_q, mask_d;
    logic       acc_q, acc_d;
    logic [CODE_W-1:0] kind_q, kind_d;
    logic       rkind_q, rkind_d;
    logic       running, handling, sample_pt;
    logic       req_trace, req_direct, req_irq, req_trap;
    logic [NUM_SRC-1:0] req, grant;
    logic       any_grant;
    logic [CODE_W-1:0] pick_code;

    exc_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pin_warm_n, pin_por_n}),
        .dout (pins_s)
    );

    assign por_s   = pins_s[0];
    assign warm_s  = pins_s[1];
    assign pins_ok = por_s & warm_s;

    assign running  = (st_q == ST_RUN);
    assign handling = (st_q == ST_RST_HANDLE) || (st_q == ST_EXC_HANDLE);

    exc_req_qual #(.MODE_W(MODE_W), .TRACE_MODE(TRACE_MODE)) u_qual (
        .running     (running),
        .handling    (handling),
        .insn_done   (insn_done),
        .handler_done(handler_done),
        .insn_ret    (insn_ret),
        .insn_flagmod(insn_flagmod),
        .trace_bit   (trace_bit),
        .irq_ctl_mode(irq_ctl_mode),
        .sleep_exec  (sleep_exec),
        .direct_req  (direct_req),
        .irq_pending (irq_pending),
        .trap_strobe (trap_strobe),
        .irq_mask    (mask_q),
        .sample_pt   (sample_pt),
        .req_trace   (req_trace),
        .req_direct  (req_direct),
        .req_irq     (req_irq),
        .req_trap    (req_trap)
    );

    // Reset slot: pin release in hold, watchdog elsewhere; blocked while a pin is low
    always_comb begin
        req            = '0;
        req[SLOT_RST]  = (st_q == ST_HOLD) ? pins_ok : (pins_ok & wdt_ovf);
        req[SLOT_TRC]  = pins_ok & req_trace;
        req[SLOT_DIR]  = pins_ok & req_direct;
        req[SLOT_IRQ]  = pins_ok & req_irq;
        req[SLOT_TRAP] = pins_ok & req_trap;
    end

    exc_prio_pick #(.N(NUM_SRC), .CODE_W(CODE_W)) u_pick (
        .req  (req),
        .grant(grant),
        .any  (any_grant),
        .code (pick_code)
    );

    // Next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD: begin
                if (pins_ok) st_d = ST_RST_HANDLE;          // release
            end
            ST_RUN, ST_RST_HANDLE, ST_EXC_HANDLE: begin
                if (!pins_ok)                  st_d = ST_HOLD;        // pin-drop
                else if (grant[SLOT_RST])      st_d = ST_RST_HANDLE;  // watchdog
                else if (any_grant)            st_d = ST_EXC_HANDLE;  // take
                else if (handling && handler_done) st_d = ST_RUN;     // resume
            end
            default: st_d = ST_HOLD;
        endcase
    end

    // Output process
    always_comb begin
        acc_d   = any_grant;
        kind_d  = any_grant ? pick_code : CODE_W'(EXC_NONE);
        rkind_d = rkind_q;
        if (!por_s)                rkind_d = 1'b0;
        else if (!warm_s)          rkind_d = 1'b1;
        else if (grant[SLOT_RST] && st_q != ST_HOLD) rkind_d = 1'b0;
        mask_d = mask_q;
        if (grant[SLOT_RST])       mask_d = 1'b1;
        else if (sample_pt)        mask_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_HOLD;
            acc_q   <= 1'b0;
            kind_q  <= '0;
            rkind_q <= 1'b0;
            mask_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            acc_q   <= acc_d;
            kind_q  <= kind_d;
            rkind_q <= rkind_d;
            mask_q  <= mask_d;
        end
    end

    assign accept     = acc_q;
    assign exc_kind   = kind_q;
    assign reset_kind = rkind_q;
    assign in_reset   = (st_q == ST_HOLD);

    // Assertions
    p_kind_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (exc_kind >= 3'd1 && exc_kind <= 3'd5));
    p_kind_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (exc_kind == 3'd0));
    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |-> !accept);
    p_por_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !por_s) |=> !reset_kind);
    p_wdt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !pins_ok) |=> !accept);
    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_no_trace_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && insn_done && insn_ret) |-> !grant[SLOT_TRC]);
    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && sample_pt) |-> !grant[SLOT_IRQ]);
    p_trap_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant[SLOT_TRAP] |-> running);
    p_take_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && exc_kind != 3'd1) |-> (st_q == ST_EXC_HANDLE));

endmodule

// File: tb/exc_arbiter_test.sv
`timescale 1ns/1ps
module exc_arbiter_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_por_n = 1'b1, pin_warm_n = 1'b1, wdt_ovf = 1'b0;
    logic trace_bit = 1'b0;
    logic [1:0] irq_ctl_mode = 2'd0;
    logic sleep_exec = 1'b0, direct_req = 1'b0, irq_pending = 1'b0, trap_strobe = 1'b0;
    logic insn_done = 1'b0, insn_ret = 1'b0, insn_flagmod = 1'b0, handler_done = 1'b0;
    logic accept, reset_kind, in_reset;
    logic [2:0] exc_kind;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    exc_arbiter uut (
        .clk(clk), .rst_n(rst_n), .pin_por_n(pin_por_n), .pin_warm_n(pin_warm_n),
        .wdt_ovf(wdt_ovf), .trace_bit(trace_bit), .irq_ctl_mode(irq_ctl_mode),
        .sleep_exec(sleep_exec), .direct_req(direct_req), .irq_pending(irq_pending),
        .trap_strobe(trap_strobe), .insn_done(insn_done), .insn_ret(insn_ret),
        .insn_flagmod(insn_flagmod), .handler_done(handler_done),
        .accept(accept), .exc_kind(exc_kind), .reset_kind(reset_kind), .in_reset(in_reset)
    );

    // {trace, mode[1:0], sleep, dreq, irq, trap, done, ret, flagmod, expected[2:0]}
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_00_0_0_0_1_0_0_0_101,  // R9 trap alone
        13'b0_00_0_0_1_0_1_0_0_100,  // R7 interrupt at completion
        13'b0_00_0_0_1_0_0_0_0_000,  // R7 interrupt without completion
        13'b0_00_0_0_1_0_1_0_1_000,  // R7 flag-modifying completion
        13'b1_10_0_0_0_0_1_0_0_010,  // R5 trace mode 2
        13'b1_00_0_0_0_0_1_0_0_000,  // R5 trace wrong mode
        13'b1_10_0_0_0_0_1_1_0_000,  // R5 trace after return
        13'b1_10_0_0_0_0_0_0_0_000,  // R5 trace without completion
        13'b0_00_1_1_0_0_0_0_0_011,  // R6 direct transition
        13'b0_00_1_0_0_0_0_0_0_000,  // R6 sleep alone
        13'b0_00_0_1_0_0_0_0_0_000,  // R6 request alone
        13'b1_10_1_1_1_1_1_0_0_010,  // R4 all but reset
        13'b0_00_1_1_1_1_1_0_0_011,  // R4 direct over irq/trap
        13'b0_00_0_0_1_1_1_0_0_100,  // R4 irq over trap
        13'b1_10_0_0_1_1_1_1_0_100,  // R4 return blocks trace
        13'b0_00_0_0_1_1_1_0_1_101,  // R4 flagmod blocks irq
        13'b1_11_0_0_1_0_1_0_0_100,  // R4 mode 3 blocks trace
        13'b1_10_0_0_1_1_1_1_1_101   // R4 only trap left
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        wdt_ovf = 0; trace_bit = 0; irq_ctl_mode = 2'd0; sleep_exec = 0; direct_req = 0;
        irq_pending = 0; trap_strobe = 0; insn_done = 0; insn_ret = 0;
        insn_flagmod = 0; handler_done = 0;
    endtask

    task automatic finish_handler();
        clear_in();
        handler_done = 1;
        tick();
        handler_done = 0;
    endtask

    initial begin
        #(5.0 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        check("R2", "in_reset during rst_n", in_reset, 1);
        check("R10", "accept during rst_n", accept, 0);
        check("R10", "kind during rst_n", exc_kind, 0);
        check("R2", "reset_kind during rst_n", reset_kind, 0);

        // R1: release, accept on third edge
        rst_n = 1;
        tick();
        check("R1", "accept edge1", accept, 0);
        tick();
        check("R1", "accept edge2", accept, 0);
        tick();
        check("R1", "accept edge3", accept, 1);
        check("R1", "kind edge3", exc_kind, 1);
        check("R1", "in_reset cleared", in_reset, 0);

        // R8: first sampling point after reset masks interrupt
        handler_done = 1; irq_pending = 1;
        tick();
        check("R10", "accept single pulse", accept, 0);
        check("R8", "irq masked after reset", accept, 0);
        handler_done = 0; insn_done = 1;
        tick();
        check("R8", "irq after mask point", exc_kind, 4);
        finish_handler();

        // Vector walk (state: running)
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            clear_in();
            trace_bit = v[12]; irq_ctl_mode = v[11:10]; sleep_exec = v[9];
            direct_req = v[8]; irq_pending = v[7]; trap_strobe = v[6];
            insn_done = v[5]; insn_ret = v[4]; insn_flagmod = v[3];
            tick();
            check("R4", $sformatf("vector %0d kind", i), exc_kind, int'(v[2:0]));
            check("R10", $sformatf("vector %0d accept", i), accept, int'(v[2:0] != 0));
            clear_in();
            if (v[2:0] != 0) finish_handler();
        end

        // R11: handling blocks run-time requests
        clear_in(); trap_strobe = 1;
        tick();
        check("R9", "trap taken", exc_kind, 5);
        clear_in(); trap_strobe = 1; insn_done = 1; irq_pending = 1;
        sleep_exec = 1; direct_req = 1;
        tick();
        check("R11", "requests ignored while handling", accept, 0);
        clear_in(); handler_done = 1; irq_pending = 1;
        tick();
        check("R11", "irq at handler end", exc_kind, 4);
        clear_in(); handler_done = 1; trace_bit = 1; irq_ctl_mode = 2'd2;
        tick();
        check("R5", "trace at handler end", exc_kind, 2);
        finish_handler();

        // R3: watchdog outranks trap
        clear_in(); wdt_ovf = 1; trap_strobe = 1;
        tick();
        check("R3", "watchdog reset kind", exc_kind, 1);
        check("R3", "watchdog is power-on", reset_kind, 0);
        clear_in(); handler_done = 1; irq_pending = 1;
        tick();
        check("R8", "irq masked after watchdog", accept, 0);
        clear_in();

        // R2/R3: power-on pin held low
        pin_por_n = 0;
        tick(); tick(); tick();
        check("R2", "in_reset por low", in_reset, 1);
        check("R2", "reset_kind por low", reset_kind, 0);
        wdt_ovf = 1; trap_strobe = 1; irq_pending = 1; insn_done = 1;
        tick();
        check("R3", "watchdog ignored in hold", accept, 0);
        tick();
        check("R2", "requests blocked in hold", accept, 0);
        clear_in();
        pin_por_n = 1;
        tick();
        check("R1", "por release edge1", accept, 0);
        tick();
        check("R1", "por release edge2", accept, 0);
        tick();
        check("R1", "por release edge3", exc_kind, 1);
        check("R2", "kind kept power-on", reset_kind, 0);
        finish_handler();

        // R2: manual pin
        pin_warm_n = 0;
        tick(); tick(); tick();
        check("R2", "in_reset manual low", in_reset, 1);
        check("R2", "reset_kind manual", reset_kind, 1);
        pin_warm_n = 1;
        tick(); tick(); tick();
        check("R1", "manual release accept", exc_kind, 1);
        check("R2", "manual kind kept", reset_kind, 1);
        finish_handler();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule